// File: doc/BRIEF.md
# Variable-Group Carry-Skip Adder

This block adds two unsigned words and a carry-in. The result is a sum word and a carry-out. The word is cut into ripple-carry groups whose widths come from a parameter list. The widths need not match. The default list puts the wider groups in the middle of the word and the narrower ones at the two ends. This balances the path from the low bits up to the first bypass against the path from the last bypass into the top bits.

Each group forms a group propagate from its operand bits. When every bit of a group propagates, a multiplexer passes the group's carry-in straight to the next group. The group's own ripple chain is bypassed. Otherwise the carry leaving the group is taken from its ripple chain.

The arithmetic is combinational. The sum and carry-out are captured in output registers that clear on a synchronous reset. A result therefore appears one clock after its operands are presented.

Top module: `skip_adder`

## Requirements
- R1: One clock after operands `a`, `b` and `cin` are sampled with reset low, `{cout, sum}` equals the unsigned value `a + b + cin`, computed to WIDTH+1 bits.
- R2: While `rst` is high at a rising clock edge, `sum` and `cout` become zero on that edge, whatever the operands are.
- R3: A group's propagate is the AND of `a[i] XOR b[i]` over all bits of that group. When it is 1, the carry passed to the next group equals the carry entering the group. In that case the group's ripple chain also produces that same carry.
- R4: When a group's propagate is 0, the carry passed onward is the group's ripple-chain carry. A carry generated inside such a group, or killed inside it, reaches the next group correctly.
- R5: When every bit of the word propagates, `cout` equals `cin`. With `cin` = 0 the sum is all ones; with `cin` = 1 the sum is zero.
- R6: The default configuration is WIDTH = 16 with group widths 2, 3, 4, 4, 3, counted from the least significant bit. A carry produced in the top bit of any group enters the next group. Elaboration fails when the listed widths do not add up to WIDTH.
- R7: `cout` is the carry leaving the most significant group after that group's bypass multiplexer. For example, 0xFFFF + 0x0001 with `cin` = 0 gives `cout` = 1 and a zero sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the most significant group |

## Verification
The bench uses four kinds of input. Uniform random operands mostly hit groups that generate or kill, so they test the ripple chains. Operands built as `b = ~a` with a few bits flipped leave most groups fully propagating, which tests the bypass multiplexers against the ripple paths. The all-propagate words 0xFFFF/0x0000 and 0x5555/0xAAAA, with both carry-in values, send one carry through every bypass at once and separate a broken skip from a broken ripple. Single carries placed on the top bit of each group test the joins between unequal groups.

// File: rtl/skip_pkg.sv
package skip_pkg;

  // majority of three inputs: carry of a full adder
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // odd parity of three inputs: sum of a full adder
  function automatic logic par3(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

endpackage

// File: rtl/skip_fa.sv
module skip_fa
  import skip_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  assign s  = par3(x, y, ci);
  assign co = maj3(x, y, ci);

endmodule

// File: rtl/skip_group.sv
module skip_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         prop,
  output logic         ripple_co,
  output logic         cout
);

  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    skip_fa u_fa (
      .x  (a[i]),
      .y  (b[i]),
      .ci (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  // one AND term over the per-bit propagates
  assign prop      = &(a ^ b);
  assign ripple_co = chain[W];
  // bypass multiplexer
  assign cout      = prop ? cin : chain[W];

endmodule

// File: rtl/skip_adder.sv
module skip_adder #(
  parameter int WIDTH = 16,
  parameter int NGRP  = 5,
  parameter int GRP_W [NGRP] = '{2, 3, 4, 4, 3}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  function automatic int grp_base(input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += GRP_W[i];
    return acc;
  endfunction

  localparam int TOTAL_W = grp_base(NGRP);

  // R6: widths must cover the word exactly
  if (TOTAL_W != WIDTH) begin : g_width_bad
    $error("skip_adder: group widths add to %0d, WIDTH is %0d", TOTAL_W, WIDTH);
  end

  logic [NGRP:0]    gcarry;
  logic [NGRP-1:0]  gprop;
  logic [NGRP-1:0]  gripple;
  logic [WIDTH-1:0] sum_c;

  assign gcarry[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = grp_base(g);
    localparam int GW = GRP_W[g];

    skip_group #(.W(GW)) u_grp (
      .a         (a[LO +: GW]),
      .b         (b[LO +: GW]),
      .cin       (gcarry[g]),
      .sum       (sum_c[LO +: GW]),
      .prop      (gprop[g]),
      .ripple_co (gripple[g]),
      .cout      (gcarry[g+1])
    );

    // R3
    bypass_agree_chk: assert property (@(posedge clk) disable iff (rst)
      gprop[g] |-> (gripple[g] == gcarry[g]));

    // R3
    skip_pass_chk: assert property (@(posedge clk) disable iff (rst)
      gprop[g] |-> (gcarry[g+1] == gcarry[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= gcarry[NGRP];
    end
  end

  // R1
  sum_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout, sum} ==
      ($past({1'b0, a}) + $past({1'b0, b}) + {{WIDTH{1'b0}}, $past(cin)})));

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (sum == '0 && !cout));

  // R5
  full_prop_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(&(a ^ b))) |-> (cout == $past(cin)));

endmodule

// File: tb/skip_adder_test.sv
`timescale 1ns/1ps
module skip_adder_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  skip_adder uut (
    .clk (clk), .rst (rst), .a (a), .b (b), .cin (cin),
    .sum (sum), .cout (cout)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                       input string req);
    @(negedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    check(req, {cout, sum}, ref_add(x, y, c));
  endtask

  initial begin
    logic [W-1:0] r;
    void'($urandom(32'd4242));
    // R2: reset clears outputs despite nonzero operands
    a = 16'hFFFF; b = 16'h0001; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", {cout, sum}, '0);
    rst = 1'b0;
    // R7: carry out of the top group
    apply(16'hFFFF, 16'h0001, 1'b0, "R7");
    apply(16'h8000, 16'h8000, 1'b0, "R7");
    // R5: every bit propagates
    apply(16'hFFFF, 16'h0000, 1'b1, "R5");
    apply(16'hFFFF, 16'h0000, 1'b0, "R5");
    apply(16'h5555, 16'hAAAA, 1'b1, "R5");
    apply(16'hAAAA, 16'h5555, 1'b0, "R5");
    // R6: carry born in the top bit of each group (boundaries at 2,5,9,13)
    foreach (r[i]) begin end
    apply(16'h0002, 16'h0002, 1'b0, "R6");
    apply(16'h0010, 16'h0010, 1'b0, "R6");
    apply(16'h0100, 16'h0100, 1'b0, "R6");
    apply(16'h1000, 16'h1000, 1'b0, "R6");
    apply(16'h1FFE, 16'h0002, 1'b0, "R6");
    // R4: generate and kill inside non-propagating groups
    apply(16'h0000, 16'h0000, 1'b1, "R4");
    apply(16'h0003, 16'h0001, 1'b0, "R4");
    apply(16'h7FFF, 16'h0000, 1'b1, "R4");
    // R3: mostly propagating operands, a few bits disturbed
    for (int n = 0; n < 600; n++) begin
      r = W'($urandom);
      apply(r, ~r ^ (W'(1) << ($urandom % W)), 1'($urandom), "R3");
    end
    // R1: uniform random operands
    for (int n = 0; n < 1500; n++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1");
    end
    // R2: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    a = 16'h1234; b = 16'hFEDC; cin = 1'b1;
    @(negedge clk);
    check("R2", {cout, sum}, '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule